// File: doc/BRIEF.md
# Playback DMA Byte Counter

This block paces the playback side of an audio DMA channel. Once playback is enabled, it holds a level DMA request. Each cycle it offers the largest chunk, in bytes, that the DMA engine may move next. It counts the bytes of every completed chunk against a programmed byte target. When a chunk lands exactly on that target, it emits a one-cycle playback interrupt strobe and starts counting again from zero.

The byte target is a 16-bit base count shifted left by a format-dependent shift of 0 to 2. While interrupts are enabled, each offered chunk is clipped so that it can end exactly on the target boundary. While interrupts are disabled, the offer is limited only by the free space at the output. For companded formats every input byte expands to two output bytes, so the usable space is half the output space.

A two-state controller (PB_IDLE, PB_RUN) owns the request. The transition START (PB_IDLE to PB_RUN) is taken when playback is enabled and programmed-I/O mode is not selected, and it clears the byte count. The transition STOP (PB_RUN to PB_IDLE) is taken when playback is disabled. In every other case the state holds (HOLD_IDLE, HOLD_RUN).

Top module: `pb_dma_counter`

## Requirements
- R1: After reset `dma_req`, `play_irq` and `chunk_max` are all 0, and `chunk_max` stays 0 whenever `dma_req` is 0.
- R2: With `play_en`=1 and `pio_sel`=0 in PB_IDLE, `dma_req` becomes 1 one clock later and the byte count restarts at 0.
- R3: While `pio_sel`=1, playback is not started from PB_IDLE and `dma_req` stays 0.
- R4: With `dma_req`=1 and `play_en`=0, `dma_req` is 0 one clock later.
- R5: While running with `irq_en`=1, `chunk_max` = min(target − count, space), where target = `base_count` << shift. The difference is taken as 0 if the count is past the target.
- R6: While running with `irq_en`=0, `chunk_max` = space, and no chunk ever raises `play_irq`.
- R7: Space is `out_space` when `companded`=0 and `out_space`>>1 when `companded`=1.
- R8: A chunk with `irq_en`=1 whose length equals target − count raises `play_irq` for exactly one cycle, one clock after the chunk strobe, and resets the count to 0.
- R9: Any other nonzero chunk accepted while running adds its length to the count, modulo 2^18.
- R10: A chunk of length 0 changes no state. A target of 0 gives `chunk_max`=0 with `irq_en`=1 and never raises `play_irq`.
- R11: A `fmt_shift` value of 3 acts as shift 2.
- R12: A chunk strobe while `dma_req`=0 is ignored. Holding `play_en` while already running does not clear the count, but a stop followed by a new start does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| play_en | input | 1 | Playback enable |
| pio_sel | input | 1 | Programmed-I/O mode select; blocks a DMA start |
| irq_en | input | 1 | Enables counting against the target and chunk clipping |
| base_count | input | 16 | Programmed base count |
| fmt_shift | input | 2 | Format shift applied to the base count (3 acts as 2) |
| companded | input | 1 | Format expands each byte to two output bytes |
| out_space | input | 18 | Free output space in bytes |
| chunk_vld | input | 1 | Strobe: a chunk transfer has completed |
| chunk_len | input | 18 | Byte length of the completed chunk |
| dma_req | output | 1 | DMA request level |
| chunk_max | output | 18 | Largest chunk allowed next, in bytes |
| play_irq | output | 1 | One-cycle playback interrupt strobe |

## Verification
The assertions watch four things on every cycle:
- the request follows the start, stop and programmed-I/O rules;
- the offered chunk never exceeds the usable space;
- while interrupts are enabled, the offered chunk never exceeds the byte target;
- an interrupt strobe only ever follows a nonzero chunk taken while running with interrupts enabled.

Some behaviour depends on the hidden byte count and can only be shown by the bench's scenarios compared against its reference model:
- the exact clipped value after partial chunks;
- the count restart on a fresh start;
- the zero-length chunk and zero target;
- the shift clamp;
- the strobe landing exactly on the boundary.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    typedef enum logic [0:0] {
        PB_IDLE = 1'b0,
        PB_RUN  = 1'b1
    } pb_state_t;
endpackage

// File: rtl/pbc_fsm.sv
module pbc_fsm
    import pbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic play_en,
    input  logic pio_sel,
    output logic running,
    output logic start
);
    pb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PB_IDLE: if (play_en && !pio_sel) state_d = PB_RUN;  // START
            PB_RUN:  if (!play_en)            state_d = PB_IDLE; // STOP
            default: state_d = PB_IDLE;
        endcase
    end

    always_comb begin
        running = 1'b0;
        start   = 1'b0;
        unique case (state_q)
            PB_IDLE: start   = play_en && !pio_sel;
            PB_RUN:  running = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pbc_window.sv
module pbc_window #(
    parameter int CNT_W     = 16,
    parameter int SHIFT_MAX = 2,
    parameter int XFER_W    = CNT_W + SHIFT_MAX
) (
    input  logic              running,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  base_count,
    input  logic [1:0]        fmt_shift,
    input  logic              companded,
    input  logic [XFER_W-1:0] out_space,
    input  logic [XFER_W-1:0] xfer,
    output logic [XFER_W-1:0] remaining,
    output logic [XFER_W-1:0] chunk_max
);
    localparam int PAD_W = XFER_W - CNT_W;

    logic [1:0]        eff_shift;
    logic [XFER_W-1:0] target;
    logic [XFER_W-1:0] space;

    always_comb begin
        eff_shift = (int'(fmt_shift) > SHIFT_MAX) ? 2'(SHIFT_MAX) : fmt_shift;
        target    = {{PAD_W{1'b0}}, base_count} << eff_shift;
        remaining = (target > xfer) ? (target - xfer) : '0;
        space     = companded ? (out_space >> 1) : out_space;
        if (!running)    chunk_max = '0;
        else if (irq_en) chunk_max = (remaining < space) ? remaining : space;
        else             chunk_max = space;
    end
endmodule

// File: rtl/pbc_tally.sv
module pbc_tally #(
    parameter int XFER_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              running,
    input  logic              irq_en,
    input  logic              chunk_vld,
    input  logic [XFER_W-1:0] chunk_len,
    input  logic [XFER_W-1:0] remaining,
    output logic [XFER_W-1:0] xfer,
    output logic              play_irq
);
    logic take, hit;

    always_comb begin
        take = running && chunk_vld && (chunk_len != '0);
        hit  = take && irq_en && (chunk_len == remaining);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer     <= '0;
            play_irq <= 1'b0;
        end else begin
            play_irq <= hit;
            if (start)     xfer <= '0;
            else if (hit)  xfer <= '0;
            else if (take) xfer <= xfer + chunk_len;
        end
    end
endmodule

// File: rtl/pb_dma_counter.sv
module pb_dma_counter #(
    parameter int CNT_W     = 16,
    parameter int SHIFT_MAX = 2,
    parameter int XFER_W    = CNT_W + SHIFT_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_en,
    input  logic              pio_sel,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  base_count,
    input  logic [1:0]        fmt_shift,
    input  logic              companded,
    input  logic [XFER_W-1:0] out_space,
    input  logic              chunk_vld,
    input  logic [XFER_W-1:0] chunk_len,
    output logic              dma_req,
    output logic [XFER_W-1:0] chunk_max,
    output logic              play_irq
);
    logic              running, start;
    logic [XFER_W-1:0] xfer, remaining;

    pbc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .play_en(play_en), .pio_sel(pio_sel),
        .running(running), .start(start)
    );

    pbc_window #(.CNT_W(CNT_W), .SHIFT_MAX(SHIFT_MAX), .XFER_W(XFER_W)) u_win (
        .running(running), .irq_en(irq_en), .base_count(base_count),
        .fmt_shift(fmt_shift), .companded(companded), .out_space(out_space),
        .xfer(xfer), .remaining(remaining), .chunk_max(chunk_max)
    );

    pbc_tally #(.XFER_W(XFER_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .start(start), .running(running),
        .irq_en(irq_en), .chunk_vld(chunk_vld), .chunk_len(chunk_len),
        .remaining(remaining), .xfer(xfer), .play_irq(play_irq)
    );

    assign dma_req = running;
endmodule

// File: rtl/pb_dma_counter_chk.sv
module pb_dma_counter_chk #(
    parameter int CNT_W     = 16,
    parameter int SHIFT_MAX = 2,
    parameter int XFER_W    = CNT_W + SHIFT_MAX
) (
    input logic              clk,
    input logic              rst_n,
    input logic              play_en,
    input logic              pio_sel,
    input logic              irq_en,
    input logic [CNT_W-1:0]  base_count,
    input logic [1:0]        fmt_shift,
    input logic              companded,
    input logic [XFER_W-1:0] out_space,
    input logic              chunk_vld,
    input logic [XFER_W-1:0] chunk_len,
    input logic              dma_req,
    input logic [XFER_W-1:0] chunk_max,
    input logic              play_irq
);
    logic [XFER_W-1:0] space_ex, target_ex;
    always_comb begin
        space_ex  = companded ? (out_space >> 1) : out_space;
        target_ex = XFER_W'(base_count) << ((fmt_shift > 2'd2) ? 2'd2 : fmt_shift);
    end

    // R2
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && play_en && !pio_sel) |=> dma_req);
    // R3
    pio_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && pio_sel) |=> !dma_req);
    // R4
    stop_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !play_en) |=> !dma_req);
    // R7
    space_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_max <= space_ex);
    // R5
    target_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && irq_en) |-> (chunk_max <= target_ex));
    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        play_irq |-> $past(chunk_vld && irq_en && dma_req && (chunk_len != '0)));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        play_irq |=> !play_irq || $past(chunk_vld));
endmodule

bind pb_dma_counter pb_dma_counter_chk #(
    .CNT_W(CNT_W), .SHIFT_MAX(SHIFT_MAX), .XFER_W(XFER_W)
) u_chk (.*);

// File: tb/sim_pb_dma_counter.sv
module sim_pb_dma_counter;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic play_en = 0, pio_sel = 0, irq_en = 0, companded = 0, chunk_vld = 0;
    logic [15:0] base_count = '0;
    logic [1:0]  fmt_shift = '0;
    logic [XW-1:0] out_space = '0, chunk_len = '0;
    logic dma_req, play_irq;
    logic [XW-1:0] chunk_max;

    int n_checks = 0, n_fail = 0;
    bit model_on = 0;
    bit m_run = 0, m_irq = 0;
    int m_xfer = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pb_dma_counter u0 (.*);

    function automatic int m_target();
        int s;
        s = (fmt_shift > 2) ? 2 : int'(fmt_shift);
        return int'(base_count) << s;
    endfunction

    function automatic int m_remaining();
        return (m_target() > m_xfer) ? m_target() - m_xfer : 0;
    endfunction

    function automatic int m_chunk();
        int sp;
        sp = companded ? int'(out_space) / 2 : int'(out_space);
        if (!m_run) return 0;
        if (irq_en) return (m_remaining() < sp) ? m_remaining() : sp;
        return sp;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_xfer = 0; m_irq = 0;
        end else begin
            bit hit;
            hit = 0;
            if (m_run && chunk_vld && chunk_len != 0) begin
                if (irq_en && int'(chunk_len) == m_remaining()) begin
                    hit = 1; m_xfer = 0;
                end else m_xfer = (m_xfer + int'(chunk_len)) % (1 << XW);
            end
            m_irq = hit;
            if (!m_run && play_en && !pio_sel) begin
                m_run = 1; m_xfer = 0;
            end else if (m_run && !play_en) m_run = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_on) begin
            check("R2/R4 model dma_req", int'(dma_req), int'(m_run));
            check("R5/R6 model chunk_max", int'(chunk_max), m_chunk());
            check("R8 model play_irq", int'(play_irq), int'(m_irq));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chunk(int len);
        step(); chunk_vld = 1; chunk_len = XW'(len);
        step(); chunk_vld = 0; chunk_len = '0;
    endtask

    task automatic sample();
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(); step(); sample();
        check("R1 reset dma_req", int'(dma_req), 0);
        check("R1 reset chunk_max", int'(chunk_max), 0);
        check("R1 reset play_irq", int'(play_irq), 0);
        rst_n = 1; model_on = 1;

        // R12: chunk while idle ignored
        out_space = 18'd100; irq_en = 1; base_count = 16'd10; fmt_shift = 2'd1;
        chunk(7); sample();
        check("R12 idle chunk ignored, idle chunk_max", int'(chunk_max), 0);

        // R3
        step(); pio_sel = 1; play_en = 1; step(); step(); sample();
        check("R3 pio blocks start", int'(dma_req), 0);
        // R2
        step(); pio_sel = 0; step(); sample();
        check("R2 start raises dma_req", int'(dma_req), 1);
        check("R2 count cleared, chunk_max=target", int'(chunk_max), 20);

        // R6 / R7
        step(); irq_en = 0; sample();
        check("R6 irq off gives space", int'(chunk_max), 100);
        step(); companded = 1; sample();
        check("R7 companded halves space", int'(chunk_max), 50);
        chunk(20); sample();
        check("R6 no irq with irq_en=0", int'(play_irq), 0);
        step(); companded = 0; irq_en = 1; play_en = 0; step(); step(); play_en = 1;
        step(); step(); sample();

        // R11
        step(); fmt_shift = 2'd3; sample();
        check("R11 shift 3 acts as 2", int'(chunk_max), 40);
        step(); fmt_shift = 2'd1; sample();
        check("R5 target 20", int'(chunk_max), 20);

        // R9, R10
        chunk(6); sample();
        check("R9 partial chunk adds", int'(chunk_max), 14);
        chunk(0); sample();
        check("R10 zero chunk no change", int'(chunk_max), 14);
        check("R10 zero chunk no irq", int'(play_irq), 0);

        // R5 min with space
        step(); out_space = 18'd5; sample();
        check("R5 space smaller", int'(chunk_max), 5);
        step(); out_space = 18'd100;

        // R8
        chunk(14); @(negedge clk); #1;
        check("R8 irq strobe", int'(play_irq), 1);
        check("R8 count reset", int'(chunk_max), 20);
        sample();
        check("R8 strobe one cycle", int'(play_irq), 0);

        // R12: holding play_en keeps count; stop and restart clears it
        chunk(4); sample();
        check("R12 running hold keeps count", int'(chunk_max), 16);
        step(); play_en = 0; step(); sample();
        check("R4 stop drops dma_req", int'(dma_req), 0);
        check("R1 idle chunk_max zero", int'(chunk_max), 0);
        step(); play_en = 1; step(); sample();
        check("R12 restart clears count", int'(chunk_max), 20);

        // R10 zero target
        step(); base_count = 16'd0; sample();
        check("R10 zero target chunk_max", int'(chunk_max), 0);
        chunk(3); sample();
        check("R10 zero target no irq", int'(play_irq), 0);

        // R9 large pattern: shift 2 with big base
        step(); base_count = 16'hFFFF; fmt_shift = 2'd2; out_space = 18'h3FFFF;
        play_en = 0; step(); step(); play_en = 1; step(); step(); sample();
        check("R5 max target", int'(chunk_max), 262140);
        chunk(262139); sample();
        check("R9 large partial", int'(chunk_max), 1);
        chunk(1); @(negedge clk); #1;
        check("R8 irq at max target", int'(play_irq), 1);

        repeat (3) step();
        model_on = 0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule